// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers 32 external interrupt lines, keeps an enable bit, a pending bit and a two-bit urgency level for each one, and offers the most urgent candidate to a processor core. Software reaches the state through a single-cycle, word-wide register port. Each state bit has one address that sets it and another that clears it. The levels are packed four to a word.

The core takes the offered interrupt with an acknowledge strobe. The block then clears that line's pending bit and pushes the line's level onto a nesting stack. The top of this stack is the threshold that any new request must beat. A return strobe pops the stack, so the interrupted level becomes the threshold again. Because every push is strictly more urgent than the entry below it, the stack never holds more than four levels.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every enable bit, pending bit and level field reads zero, and `irq_req_o` is low.
- R2: Word byte address 0x000 sets enable bits where the write data is 1, and 0x080 clears them. Zero bits in the write data leave the state unchanged. Reads at either address return the current enable bits.
- R3: Addresses 0x100 (set) and 0x180 (clear) act on the pending bits with the same write-one semantics. Reads at either address return the current pending bits.
- R4: The level word at 0x300+4n holds lines 4n..4n+3. Line k stores its level in bits [(k mod 4)*8+7 : (k mod 4)*8+6]. All other bits of the word read zero, and writes to them are discarded.
- R5: A write whose byte strobe `wstrb_i` is not 4'b1111 changes no register.
- R6: `irq_req_o` is high exactly when some line is both enabled and pending and its level beats the threshold. When it is high, `irq_num_o` and `irq_prio_o` give the selected line and its level. A pending line that is disabled is never selected.
- R7: Among the enabled pending lines, the one with the numerically smallest level is selected. Equal levels go to the lowest line number.
- R8: A 0-to-1 transition on `irq_i[k]` sets pending bit k. Holding the input high does not set the bit again after software clears it.
- R9: `ack_i` taken while `irq_req_o` is high clears the pending bit of `irq_num_o` and pushes its level. `ack_i` while `irq_req_o` is low has no effect.
- R10: `eoi_i` pops one level from the stack. It is ignored when the stack is empty. When `ack_i` and `eoi_i` arrive in the same cycle, only the pop happens.
- R11: The threshold is the top level on the stack, or no threshold when the stack is empty. A new line preempts only when its level is strictly smaller than the threshold, so nesting reaches at most four levels.
- R12: `rdata_o` is zero when `re_i` is low or the address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Byte address (bits [1:0] ignored) |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Byte strobes; only all-ones writes take effect |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Combinational read data |
| irq_i | input | 32 | Interrupt lines, edge detected |
| ack_i | input | 1 | Core takes the offered interrupt |
| eoi_i | input | 1 | Core returns from the current handler |
| irq_req_o | output | 1 | Request to the core |
| irq_num_o | output | 5 | Selected line number |
| irq_prio_o | output | 2 | Level of the selected line |

## Verification
The properties assume a core that pulses `ack_i` only in answer to a request, and that never raises a new edge on the line being acknowledged in that same cycle. They also assume `eoi_i` only while a handler is in progress, except where the bench deliberately sends an extra return to an empty stack. The stimulus follows these rules. It drives every strobe for a single cycle between falling edges and holds `irq_i` at zero except during the edge-detection test. The nesting sequence is ordered so that each acknowledge answers a request that is visible at the ports.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned STRB_W  = BUS_W / 8;
  localparam int unsigned FLD_PER = 4;

  // word indices (byte offset >> 2)
  localparam int unsigned W_SETEN = 'h000 >> 2;
  localparam int unsigned W_CLREN = 'h080 >> 2;
  localparam int unsigned W_SETPD = 'h100 >> 2;
  localparam int unsigned W_CLRPD = 'h180 >> 2;
  localparam int unsigned W_PRIO  = 'h300 >> 2;

  typedef enum logic [2:0] {
    RS_NONE, RS_SETEN, RS_CLREN, RS_SETPD, RS_CLRPD, RS_PRIO
  } rsel_e;

  function automatic logic [BUS_W-1:0] low_mask(int unsigned pw);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int j = 0; j < int'(FLD_PER); j++) m[j*8 +: 8] = 8'hFF >> pw;
    return m;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned PRIO_W  = 2,
  parameter int unsigned ADDR_W  = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [BUS_W-1:0]          wdata_i,
  input  logic [STRB_W-1:0]         wstrb_i,
  input  logic                      we_i,
  input  logic                      re_i,
  output logic [BUS_W-1:0]          rdata_o,
  input  logic [NUM_IRQ-1:0]        irq_i,
  input  logic [NUM_IRQ-1:0]        ack_clr_i,
  output logic [NUM_IRQ-1:0]        en_o,
  output logic [NUM_IRQ-1:0]        pend_o,
  output logic [NUM_IRQ*PRIO_W-1:0] prio_o
);
  localparam int unsigned NREG   = (NUM_IRQ + FLD_PER - 1) / FLD_PER;
  localparam int unsigned PREG_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]  widx;
  logic [PREG_W-1:0]  preg;
  rsel_e              sel;
  logic               wr_ok;
  logic [NUM_IRQ-1:0] en_q, pend_q, irq_q, wmask, edge_set;
  logic [PRIO_W-1:0]  prio_q [NUM_IRQ];
  logic [BUS_W-1:0]   rd;

  assign widx  = addr_i[ADDR_W-1:2];
  assign wr_ok = we_i && (wstrb_i == '1);
  assign wmask = wdata_i[NUM_IRQ-1:0];

  always_comb begin
    sel  = RS_NONE;
    preg = '0;
    if (widx == WIDX_W'(W_SETEN))      sel = RS_SETEN;
    else if (widx == WIDX_W'(W_CLREN)) sel = RS_CLREN;
    else if (widx == WIDX_W'(W_SETPD)) sel = RS_SETPD;
    else if (widx == WIDX_W'(W_CLRPD)) sel = RS_CLRPD;
    else if (widx >= WIDX_W'(W_PRIO) && widx < WIDX_W'(W_PRIO + NREG)) begin
      sel  = RS_PRIO;
      preg = PREG_W'(widx - WIDX_W'(W_PRIO));
    end
  end

  assign edge_set = irq_i & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= '0;
    end else begin
      irq_q <= irq_i;
      if (wr_ok && sel == RS_SETEN) en_q <= en_q | wmask;
      else if (wr_ok && sel == RS_CLREN) en_q <= en_q & ~wmask;
      pend_q <= (pend_q & ~ack_clr_i
                 & ~((wr_ok && sel == RS_CLRPD) ? wmask : '0))
                | ((wr_ok && sel == RS_SETPD) ? wmask : '0)
                | edge_set;
    end
  end

  for (genvar g = 0; g < int'(NUM_IRQ); g++) begin : g_fld
    localparam int unsigned REG = g / FLD_PER;
    localparam int unsigned MSB = (g % FLD_PER) * 8 + 7;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[g] <= '0;
      else if (wr_ok && sel == RS_PRIO && preg == PREG_W'(REG))
        prio_q[g] <= wdata_i[MSB -: PRIO_W];
    end
    assign prio_o[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  always_comb begin
    rd = '0;
    unique case (sel)
      RS_SETEN, RS_CLREN: rd[NUM_IRQ-1:0] = en_q;
      RS_SETPD, RS_CLRPD: rd[NUM_IRQ-1:0] = pend_q;
      RS_PRIO: begin
        for (int j = 0; j < int'(FLD_PER); j++) begin
          if (int'(preg) * int'(FLD_PER) + j < int'(NUM_IRQ))
            rd[j*8+7 -: PRIO_W] = prio_q[int'(preg) * int'(FLD_PER) + j];
        end
      end
      default: rd = '0;
    endcase
  end

  assign rdata_o = re_i ? rd : '0;
  assign en_o    = en_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned PRIO_W  = 2,
  localparam int unsigned NUM_W  = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]        cand_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  output logic                      vld_o,
  output logic [NUM_W-1:0]          num_o,
  output logic [PRIO_W-1:0]         prio_o
);
  logic [PRIO_W-1:0] best;

  // descending scan with <= lets the lower index win a tie
  always_comb begin
    vld_o = 1'b0;
    num_o = '0;
    best  = '1;
    for (int i = int'(NUM_IRQ) - 1; i >= 0; i--) begin
      if (cand_i[i] && (!vld_o || prio_i[i*PRIO_W +: PRIO_W] <= best)) begin
        vld_o = 1'b1;
        num_o = NUM_W'(i);
        best  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
    prio_o = vld_o ? best : '0;
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned DEPTH = 1 << PRIO_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] lvl_i,
  output logic [CNT_W-1:0]  depth_o,
  output logic              thr_vld_o,
  output logic [PRIO_W-1:0] thr_o
);
  logic [CNT_W-1:0]  depth_q;
  logic [PRIO_W-1:0] lvl_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
    end else if (pop_i) begin
      if (depth_q != '0) depth_q <= depth_q - CNT_W'(1);
    end else if (push_i && depth_q < CNT_W'(DEPTH)) begin
      depth_q <= depth_q + CNT_W'(1);
    end
  end

  for (genvar s = 0; s < int'(DEPTH); s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[s] <= '0;
      else if (push_i && !pop_i && depth_q == CNT_W'(s)) lvl_q[s] <= lvl_i;
    end
  end

  always_comb begin
    thr_o = '0;
    for (int i = 0; i < int'(DEPTH); i++)
      if (depth_q == CNT_W'(i + 1)) thr_o = lvl_q[i];
  end

  assign thr_vld_o = (depth_q != '0);
  assign depth_o   = depth_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned PRIO_W  = 2,
  parameter int unsigned ADDR_W  = 10,
  localparam int unsigned NUM_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic [STRB_W-1:0]  wstrb_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [BUS_W-1:0]   rdata_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  output logic               irq_req_o,
  output logic [NUM_W-1:0]   irq_num_o,
  output logic [PRIO_W-1:0]  irq_prio_o
);
  localparam int unsigned CNT_W = $clog2((1 << PRIO_W) + 1);

  logic [NUM_IRQ-1:0]        en_q, pend_q, ack_clr;
  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic                      win_vld, thr_vld, push;
  logic [NUM_W-1:0]          win_num;
  logic [PRIO_W-1:0]         win_prio, thr;
  logic [CNT_W-1:0]          depth;

  irq_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wstrb_i, .we_i, .re_i, .rdata_o,
    .irq_i, .ack_clr_i(ack_clr), .en_o(en_q), .pend_o(pend_q), .prio_o(prio_flat)
  );

  irq_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .cand_i(en_q & pend_q), .prio_i(prio_flat),
    .vld_o(win_vld), .num_o(win_num), .prio_o(win_prio)
  );

  irq_nest_stack #(.PRIO_W(PRIO_W)) u_stack (
    .clk_i, .rst_ni, .push_i(push), .pop_i(eoi_i), .lvl_i(win_prio),
    .depth_o(depth), .thr_vld_o(thr_vld), .thr_o(thr)
  );

  assign irq_req_o  = win_vld && (!thr_vld || win_prio < thr);
  assign irq_num_o  = win_num;
  assign irq_prio_o = win_prio;
  assign push       = ack_i && irq_req_o && !eoi_i;
  assign ack_clr    = push ? (NUM_IRQ'(1) << win_num) : '0;
endmodule

// File: rtl/irq_chk.sv
module irq_chk
  import irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned PRIO_W  = 2,
  parameter int unsigned ADDR_W  = 10,
  localparam int unsigned NUM_W  = $clog2(NUM_IRQ),
  localparam int unsigned DEPTH  = 1 << PRIO_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned NREG   = (NUM_IRQ + FLD_PER - 1) / FLD_PER
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               re_i,
  input logic [BUS_W-1:0]   rdata_o,
  input logic               ack_i,
  input logic               eoi_i,
  input logic               irq_req_o,
  input logic [NUM_W-1:0]   irq_num_o,
  input logic [PRIO_W-1:0]  irq_prio_o,
  input logic [NUM_IRQ-1:0] en_i,
  input logic [NUM_IRQ-1:0] pend_i,
  input logic [CNT_W-1:0]   depth_i,
  input logic               thr_vld_i,
  input logic [PRIO_W-1:0]  thr_i
);
  localparam logic [BUS_W-1:0] LOWM = low_mask(PRIO_W);
  logic prio_rd;
  assign prio_rd = re_i && addr_i[ADDR_W-1:2] >= (ADDR_W-2)'(W_PRIO)
                   && addr_i[ADDR_W-1:2] < (ADDR_W-2)'(W_PRIO + NREG);

  // R6
  req_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> en_i[irq_num_o] && pend_i[irq_num_o]);
  // R11
  req_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && thr_vld_i |-> irq_prio_o < thr_i);
  // R9
  ack_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && irq_req_o && !eoi_i |=> depth_i == $past(depth_i) + CNT_W'(1));
  // R10
  eoi_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i && depth_i != '0 |=> depth_i == $past(depth_i) - CNT_W'(1));
  // R10
  eoi_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i && depth_i == '0 |=> depth_i == '0);
  // R11
  depth_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_i <= CNT_W'(DEPTH));
  // R4
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_rd |-> (rdata_o & LOWM) == '0);
  // R12
  idle_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> rdata_o == '0);
endmodule

bind irq_prio_ctrl irq_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .re_i(re_i), .rdata_o(rdata_o),
  .ack_i(ack_i), .eoi_i(eoi_i), .irq_req_o(irq_req_o), .irq_num_o(irq_num_o),
  .irq_prio_o(irq_prio_o), .en_i(en_q), .pend_i(pend_q), .depth_i(depth),
  .thr_vld_i(thr_vld), .thr_i(thr)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic        clk_i = 0, rst_ni = 0;
  logic [9:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  wstrb_i = '0;
  logic        we_i = 0, re_i = 0, ack_i = 0, eoi_i = 0;
  logic [31:0] irq_i = '0;
  logic [31:0] rdata_o;
  logic        irq_req_o;
  logic [4:0]  irq_num_o;
  logic [1:0]  irq_prio_o;
  int checks = 0, fails = 0;
  logic [31:0] d, v, m;
  logic [1:0]  lv [32];

  always #2.5 clk_i = ~clk_i;

  irq_prio_ctrl u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] dat, logic [3:0] s = 4'hF);
    @(negedge clk_i); addr_i = a; wdata_i = dat; wstrb_i = s; we_i = 1;
    @(negedge clk_i); we_i = 0; wstrb_i = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] r);
    addr_i = a; re_i = 1; #1; r = rdata_o; re_i = 0;
  endtask

  task automatic pulse(logic a, logic e);
    @(negedge clk_i); ack_i = a; eoi_i = e;
    @(negedge clk_i); ack_i = 0; eoi_i = 0; #1;
  endtask

  function automatic logic [1:0] lvl_of(int i);
    return 2'(((i * 3) + (i >> 3)) & 3);
  endfunction

  task automatic req_chk(string tag, logic r, int n);
    #1;
    chk(tag, {31'd0, irq_req_o}, {31'd0, r});
    if (r) chk(tag, {27'd0, irq_num_o}, 32'(n));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    rd(10'h000, d); chk("R1 en", d, 0);
    rd(10'h100, d); chk("R1 pend", d, 0);
    for (int n = 0; n < 8; n++) begin rd(10'(10'h300 + 4*n), d); chk("R1 prio", d, 0); end
    req_chk("R1 req", 0, 0);

    // R2 enable set/clear, write-one semantics
    wr(10'h000, 32'h0000_00F0);
    wr(10'h000, 32'h0);
    rd(10'h000, d); chk("R2 set", d, 32'hF0);
    rd(10'h080, d); chk("R2 rd clr addr", d, 32'hF0);
    wr(10'h080, 32'h30);
    rd(10'h000, d); chk("R2 clr", d, 32'hC0);
    wr(10'h080, 32'hFFFF_FFFF);
    // R12 unmapped / idle read
    rd(10'h004, d); chk("R12 unmapped", d, 0);
    rd(10'h200, d); chk("R12 unmapped", d, 0);
    #1; chk("R12 idle", rdata_o, 0);

    // R4 level field placement, low bits dropped
    for (int i = 0; i < 32; i++) lv[i] = lvl_of(i);
    for (int n = 0; n < 8; n++) begin
      v = '0;
      for (int j = 0; j < 4; j++)
        v[j*8 +: 8] = {lv[4*n+j], 6'((j * 5 + n * 11) & 6'h3F)};
      wr(10'(10'h300 + 4*n), v);
      rd(10'(10'h300 + 4*n), d); chk("R4 field", d, v & 32'hC0C0_C0C0);
    end

    // R5 partial strobe ignored
    rd(10'h300, v);
    wr(10'h300, 32'hFFFF_FFFF, 4'b0111);
    rd(10'h300, d); chk("R5 prio strobe", d, v);
    wr(10'h000, 32'hFFFF_FFFF, 4'b1110);
    rd(10'h000, d); chk("R5 en strobe", d, 0);

    // R3 pending with line disabled, R6 no request
    wr(10'h100, 32'h20);
    rd(10'h100, d); chk("R3 pend set", d, 32'h20);
    rd(10'h180, d); chk("R3 rd clr addr", d, 32'h20);
    req_chk("R6 disabled", 0, 0);
    wr(10'h000, 32'h20);
    req_chk("R6 enabled", 1, 5);
    chk("R6 level", {30'd0, irq_prio_o}, {30'd0, lv[5]});
    wr(10'h180, 32'h20);
    rd(10'h100, d); chk("R3 pend clr", d, 0);
    wr(10'h000, 32'hFFFF_FFFF);

    // R6 single-line sweep
    for (int k = 0; k < 32; k++) begin
      wr(10'h100, 32'(1) << k);
      req_chk("R6 single", 1, k);
      chk("R6 single lvl", {30'd0, irq_prio_o}, {30'd0, lv[k]});
      wr(10'h180, 32'hFFFF_FFFF);
    end

    // R7 multi-line arbitration
    for (int t = 0; t < 24; t++) begin
      int bn; logic [1:0] bl; logic any;
      m = (32'(t) * 32'h9E37_79B9) >> (t % 5);
      any = 0; bn = 0; bl = 3;
      for (int i = 0; i < 32; i++)
        if (m[i] && (!any || lv[i] < bl)) begin any = 1; bn = i; bl = lv[i]; end
      if (m != 0) wr(10'h100, m);
      req_chk("R7 arb", any, bn);
      if (any) chk("R7 arb lvl", {30'd0, irq_prio_o}, {30'd0, bl});
      wr(10'h180, 32'hFFFF_FFFF);
    end

    // R8 edge detection
    @(negedge clk_i); irq_i[9] = 1;
    @(negedge clk_i);
    rd(10'h100, d); chk("R8 edge", d, 32'h200);
    wr(10'h180, 32'h200);
    repeat (3) @(negedge clk_i);
    rd(10'h100, d); chk("R8 level held", d, 0);
    irq_i[9] = 0;
    @(negedge clk_i); irq_i[9] = 1;
    @(negedge clk_i); irq_i[9] = 0;
    rd(10'h100, d); chk("R8 re-edge", d, 32'h200);
    wr(10'h180, 32'hFFFF_FFFF);

    // nesting: irq0=3 irq1=2 irq2=1 irq3=0 irq4..7=3
    wr(10'h300, 32'h0040_80C0);
    wr(10'h304, 32'hC0C0_C0C0);
    pulse(1, 0); // R9 ack with no request
    wr(10'h100, 32'h10);
    req_chk("R9 idle ack ignored", 1, 4);
    pulse(1, 0);
    rd(10'h100, d); chk("R9 pend cleared", d, 0);
    req_chk("R9 no req", 0, 0);
    wr(10'h100, 32'h1);
    req_chk("R11 equal no preempt", 0, 0);
    wr(10'h100, 32'h2);
    req_chk("R11 preempt 1", 1, 1);
    pulse(1, 0);
    wr(10'h100, 32'h4);
    req_chk("R11 preempt 2", 1, 2);
    pulse(1, 0);
    wr(10'h100, 32'h8);
    req_chk("R11 preempt 3", 1, 3);
    pulse(1, 0);
    req_chk("R11 depth4", 0, 0);
    pulse(0, 1);
    pulse(0, 1);
    pulse(0, 1);
    req_chk("R10 pop to lvl3", 0, 0);
    pulse(0, 1);
    req_chk("R10 empty", 1, 0);
    pulse(0, 1); // extra return, stack empty
    req_chk("R10 empty eoi ignored", 1, 0);
    pulse(1, 0);
    wr(10'h100, 32'h10);
    req_chk("R10 thr restored", 0, 0);
    wr(10'h100, 32'h2);
    req_chk("R10 before both", 1, 1);
    pulse(1, 1);
    req_chk("R10 both strobes", 1, 1);
    rd(10'h100, d); chk("R10 pend kept", d & 32'h2, 32'h2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule